// File: doc/BRIEF.md
# Keyed Dual-Stage Watchdog Timer

A watchdog counter paced by a slow tick enable (nominally 32 kHz). Software programs a timeout length and a mode over a small register bus. From then on it must reload the counter with a kick command before the count runs out. Every write that changes state must carry a fixed key value, so a stray store cannot disarm, retune or trigger the watchdog.

In single-stage mode, expiry asserts the reset request output. In dual mode with the interrupt allowed, the first expiry raises a level interrupt (the warning) and restarts the count from the full length. Reset is requested only if a second full period passes with no kick. A separate keyed command requests reset at once, whatever the counter is doing. The reset request is a pulse of a fixed number of clock cycles, meant for a system reset controller.

Top module: `keyed_wdt`

## Requirements
- R1: After reset, `irq_o` and `rst_req_o` are low, and the mode register (offset 0x00) and the length register (offset 0x04) both read 0.
- R2: A write to offset 0x00 is taken only when data bits 31:24 equal 0x22. It sets enable (bit 0), interrupt enable (bit 3) and dual mode (bit 6). A read returns those three bits in place and zero elsewhere. A write with another key changes nothing.
- R3: A write to offset 0x04 is taken only when data bits 4:0 equal 0x08. It stores the length field from bits 15:5, in units of UNIT_TICKS ticks. A read returns the field in bits 15:5 and zero elsewhere. A write with another key changes nothing.
- R4: In single-stage mode, `rst_req_o` rises in the clock cycle after the tick that completes length×UNIT_TICKS ticks since the last load. `irq_o` stays low.
- R5: With dual mode and interrupt enable both set, the first expiry raises `irq_o` and restarts the count, with no reset request. A second expiry with no kick in between raises `rst_req_o`, clears `irq_o` and returns the block to the first stage.
- R6: With dual mode set but interrupt enable clear, the first expiry requests reset, as in single-stage mode.
- R7: Writing exactly 0x1971 to offset 0x08 reloads the count from the stored length, clears `irq_o` and returns the block to the first stage. Any other value there has no effect.
- R8: Writing exactly 0x1209 to offset 0x14 raises `rst_req_o` in the next cycle, even when the watchdog is disabled. Any other value there has no effect.
- R9: `rst_req_o` stays high for exactly RST_CYCLES clock cycles per request.
- R10: Clearing enable freezes the count and clears `irq_o` and the stage. Setting enable from 0 reloads the count from the stored length.
- R11: A stored length of 0 expires after UNIT_TICKS ticks, the same as a length of 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | One-cycle pulse per slow-clock tick |
| bus_wr_i | input | 1 | Write strobe, one cycle per write |
| bus_addr_i | input | ADDR_W | Byte offset of the register |
| bus_wdata_i | input | 32 | Write data, including the key |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i` (combinational) |
| irq_o | output | 1 | Warning interrupt level (dual mode) |
| rst_req_o | output | 1 | Reset request pulse |

## Verification
Every effect is due one clock edge after its cause. A keyed write takes effect at the edge that samples the strobe. A tick that completes a period sets the interrupt or the reset request at that same edge. Read data follows the address with no delay. The bench drives each write strobe and each tick for exactly one cycle between falling edges and samples on the next falling edge, so each check falls in the first cycle where the new value is due. Expiry checks sample one tick before the deadline, where nothing may have happened yet, and again at the deadline. Pulse widths are counted on falling edges.

// File: rtl/keyed_wdt_pkg.sv
// Package: register offsets, key values, field positions and the stage type
// shared by the watchdog modules. Assumes a 32-bit data bus.
package keyed_wdt_pkg;
    localparam int DATA_W = 32;

    localparam logic [7:0] OFS_MODE  = 8'h00;
    localparam logic [7:0] OFS_LEN   = 8'h04;
    localparam logic [7:0] OFS_KICK  = 8'h08;
    localparam logic [7:0] OFS_SWRST = 8'h14;

    localparam logic [7:0]  MODE_KEY  = 8'h22;
    localparam logic [4:0]  LEN_KEY   = 5'h08;
    localparam logic [31:0] KICK_CODE = 32'h0000_1971;
    localparam logic [31:0] RST_CODE  = 32'h0000_1209;

    localparam int BIT_EN    = 0;
    localparam int BIT_IRQEN = 3;
    localparam int BIT_DUAL  = 6;
    localparam int LEN_LSB   = 5;

    typedef enum logic {
        STG_WATCH = 1'b0,
        STG_GRACE = 1'b1
    } wdt_stage_e;
endpackage

// File: rtl/keyed_wdt_regs.sv
// Register file: checks the key on each write, holds mode and length, and
// turns kick, enable changes and the software reset code into single-cycle
// pulses. Assumes a one-cycle write strobe; reads are combinational.
module keyed_wdt_regs
    import keyed_wdt_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LEN_W  = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              en_o,
    output logic              irq_en_o,
    output logic              dual_o,
    output logic [LEN_W-1:0]  len_o,
    output logic              load_o,
    output logic              stop_o,
    output logic              swrst_o
);
    localparam int LEN_MSB = LEN_LSB + LEN_W - 1;

    logic mode_hit, len_hit, kick_hit;
    logic mode_addr, len_addr;

    // Decode the address and key of the current write.
    always_comb begin
        mode_addr = wr_i && (addr_i == ADDR_W'(OFS_MODE));
        len_addr  = wr_i && (addr_i == ADDR_W'(OFS_LEN));
        mode_hit  = mode_addr && (wdata_i[31:24] == MODE_KEY);
        len_hit   = len_addr && (wdata_i[4:0] == LEN_KEY);
        kick_hit  = wr_i && (addr_i == ADDR_W'(OFS_KICK)) && (wdata_i == KICK_CODE);
        swrst_o   = wr_i && (addr_i == ADDR_W'(OFS_SWRST)) && (wdata_i == RST_CODE);
        load_o    = kick_hit || (mode_hit && wdata_i[BIT_EN] && !en_o);
        stop_o    = mode_hit && !wdata_i[BIT_EN];
    end

    // Store the mode bits on a keyed mode write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_o     <= 1'b0;
            irq_en_o <= 1'b0;
            dual_o   <= 1'b0;
        end else if (mode_hit) begin
            en_o     <= wdata_i[BIT_EN];
            irq_en_o <= wdata_i[BIT_IRQEN];
            dual_o   <= wdata_i[BIT_DUAL];
        end
    end

    // Store the length field on a keyed length write.
    always_ff @(posedge clk) begin
        if (!rst_n) len_o <= '0;
        else if (len_hit) len_o <= wdata_i[LEN_MSB:LEN_LSB];
    end

    // Return stored fields in place, key and unused bits as zero.
    always_comb begin
        rdata_o = '0;
        if (addr_i == ADDR_W'(OFS_MODE)) begin
            rdata_o[BIT_EN]    = en_o;
            rdata_o[BIT_IRQEN] = irq_en_o;
            rdata_o[BIT_DUAL]  = dual_o;
        end else if (addr_i == ADDR_W'(OFS_LEN)) begin
            rdata_o[LEN_MSB:LEN_LSB] = len_o;
        end
    end

    // R2
    mode_keyed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_addr && wdata_i[31:24] != MODE_KEY) |=> $stable({en_o, irq_en_o, dual_o}));
    // R3
    len_keyed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (len_addr && wdata_i[4:0] != LEN_KEY) |=> $stable(len_o));
endmodule

// File: rtl/keyed_wdt_counter.sv
// Timeout counter: a prescaler divides the tick by UNIT_TICKS and a unit
// counter counts down the length. It reloads itself on expiry and on a load.
// Assumes tick_i is a one-cycle enable.
module keyed_wdt_counter #(
    parameter int UNIT_TICKS = 512,
    parameter int LEN_W      = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             tick_i,
    input  logic             load_i,
    input  logic [LEN_W-1:0] len_i,
    output logic             expire_o
);
    localparam int PRE_W = (UNIT_TICKS > 1) ? $clog2(UNIT_TICKS) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(UNIT_TICKS - 1);

    logic [PRE_W-1:0] pre_q;
    logic [LEN_W-1:0] unit_q;
    logic             unit_end;

    // Flag the tick that completes the last unit.
    always_comb begin
        unit_end = en_i && tick_i && !load_i && (pre_q == PRE_LAST);
        expire_o = unit_end && (unit_q <= LEN_W'(1));
    end

    // Advance the prescaler and the unit count, reloading on load or expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q  <= '0;
            unit_q <= '0;
        end else if (load_i) begin
            pre_q  <= '0;
            unit_q <= len_i;
        end else if (en_i && tick_i) begin
            if (pre_q == PRE_LAST) begin
                pre_q  <= '0;
                unit_q <= expire_o ? len_i : unit_q - LEN_W'(1);
            end else begin
                pre_q <= pre_q + PRE_W'(1);
            end
        end
    end

    // R7
    load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (unit_q == $past(len_i)) && (pre_q == '0));
    // R10
    freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i && !load_i) |=> $stable({unit_q, pre_q}));
endmodule

// File: rtl/keyed_wdt_stage.sv
// Stage and output logic: tracks warning and final stage, holds the
// interrupt level and times the reset request pulse. Assumes expire_i
// and swrst_i are single-cycle pulses.
module keyed_wdt_stage
    import keyed_wdt_pkg::*;
#(
    parameter int RST_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic irq_en_i,
    input  logic dual_i,
    input  logic expire_i,
    input  logic clear_i,
    input  logic swrst_i,
    output logic irq_o,
    output logic rst_req_o
);
    localparam int RC_W = $clog2(RST_CYCLES + 1);

    wdt_stage_e      stage_q;
    logic            bark;
    logic [RC_W-1:0] rc_q;

    // A first expiry in dual mode with interrupt allowed is a warning only.
    always_comb bark = expire_i && (stage_q == STG_WATCH) && dual_i && irq_en_i;

    // Move between stages and hold the interrupt level.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i || !en_i) begin
            stage_q <= STG_WATCH;
            irq_o   <= 1'b0;
        end else if (expire_i) begin
            stage_q <= bark ? STG_GRACE : STG_WATCH;
            irq_o   <= bark;
        end
    end

    // Time the reset request pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) rc_q <= '0;
        else if (swrst_i || (expire_i && !bark)) rc_q <= RC_W'(RST_CYCLES);
        else if (rc_q != '0) rc_q <= rc_q - RC_W'(1);
    end

    always_comb rst_req_o = (rc_q != '0);

    // R10
    irq_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> en_i);
    // R5
    bark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bark && !clear_i) |=> irq_o && !rst_req_o);
    // R5
    bite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expire_i && stage_q == STG_GRACE) |=> rst_req_o && !irq_o);
    // R8
    swrst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        swrst_i |=> rst_req_o);
endmodule

// File: rtl/keyed_wdt.sv
// Top of the keyed dual-stage watchdog: connects the register file, the
// timeout counter and the stage logic. Assumes a synchronous active-low
// reset and a tick enable no faster than the clock.
module keyed_wdt #(
    parameter int ADDR_W     = 8,
    parameter int LEN_W      = 11,
    parameter int UNIT_TICKS = 512,
    parameter int RST_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [31:0]       bus_wdata_i,
    output logic [31:0]       bus_rdata_o,
    output logic              irq_o,
    output logic              rst_req_o
);
    logic             en, irq_en, dual, load, stop, swrst, expire;
    logic [LEN_W-1:0] len;

    keyed_wdt_regs #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_i(bus_wr_i), .addr_i(bus_addr_i),
        .wdata_i(bus_wdata_i), .rdata_o(bus_rdata_o), .en_o(en),
        .irq_en_o(irq_en), .dual_o(dual), .len_o(len), .load_o(load),
        .stop_o(stop), .swrst_o(swrst)
    );

    keyed_wdt_counter #(.UNIT_TICKS(UNIT_TICKS), .LEN_W(LEN_W)) cnt_i (
        .clk(clk), .rst_n(rst_n), .en_i(en), .tick_i(tick_i),
        .load_i(load), .len_i(len), .expire_o(expire)
    );

    keyed_wdt_stage #(.RST_CYCLES(RST_CYCLES)) stage_i (
        .clk(clk), .rst_n(rst_n), .en_i(en), .irq_en_i(irq_en),
        .dual_i(dual), .expire_i(expire), .clear_i(load || stop),
        .swrst_i(swrst), .irq_o(irq_o), .rst_req_o(rst_req_o)
    );
endmodule

// File: tb/keyed_wdt_tb_top.sv
`timescale 1ns/100ps
// Bench: sweeps timeout lengths in single and dual mode on a small
// configuration and checks keys, kick, stop, software reset and pulse width.
module keyed_wdt_tb_top;
    localparam int U   = 4;
    localparam int RST = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        wr = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq, rreq;
    int          n_chk = 0, n_fail = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    keyed_wdt #(.ADDR_W(8), .LEN_W(11), .UNIT_TICKS(U), .RST_CYCLES(RST)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .bus_wr_i(wr),
        .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
        .irq_o(irq), .rst_req_o(rreq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); wr = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr = 1'b0; addr = '0; wdata = '0;
    endtask

    task automatic rd_reg(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk); addr = a; #1 d = rdata;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    task automatic pulse_len(output int n);
        n = 0;
        while (rreq && n < 20) begin n++; @(negedge clk); end
    endtask

    function automatic logic [31:0] mode_w(input bit en, input bit ie, input bit du);
        return {8'h22, 17'h0, du, 2'b0, ie, 2'b0, en};
    endfunction

    function automatic logic [31:0] len_w(input int l);
        return (32'(l) << 5) | 32'h8;
    endfunction

    task automatic setup(input int l, input bit ie, input bit du);
        wr_reg(8'h00, mode_w(0, 0, 0));
        wr_reg(8'h04, len_w(l));
        wr_reg(8'h00, mode_w(1, ie, du));
    endtask

    initial begin
        logic [31:0] v;
        int pl;
        repeat (3) @(negedge clk);
        chk("R1 irq", irq, 0); chk("R1 rst", rreq, 0);
        rd_reg(8'h00, v); chk("R1 mode", v, 0);
        rd_reg(8'h04, v); chk("R1 len", v, 0);
        rst_n = 1'b1;

        // R2 key and field positions
        wr_reg(8'h00, 32'h2100_005F); rd_reg(8'h00, v); chk("R2 bad key", v, 0);
        wr_reg(8'h00, 32'h2200_005F); rd_reg(8'h00, v); chk("R2 fields", v, 32'h49);
        wr_reg(8'h00, mode_w(0, 0, 0)); rd_reg(8'h00, v); chk("R2 clear", v, 0);
        // R3 key and field
        wr_reg(8'h04, len_w(5)); rd_reg(8'h04, v); chk("R3 field", v, 32'hA0);
        wr_reg(8'h04, (32'd7 << 5) | 32'h9); rd_reg(8'h04, v); chk("R3 bad key", v, 32'hA0);
        wr_reg(8'h04, len_w(5) | 32'h0010_0000); rd_reg(8'h04, v); chk("R3 upper bits", v, 32'hA0);

        // R4 R9 single-stage sweep
        for (int l = 1; l <= 4; l++) begin
            setup(l, 0, 0);
            ticks(l * U - 1); chk("R4 early rst", rreq, 0);
            ticks(1); chk("R4 rst due", rreq, 1); chk("R4 irq", irq, 0);
            pulse_len(pl); chk("R9 width", pl, RST);
        end
        // R5 dual-stage sweep
        for (int l = 1; l <= 3; l++) begin
            setup(l, 1, 1);
            ticks(l * U - 1); chk("R5 early irq", irq, 0);
            ticks(1); chk("R5 bark", irq, 1); chk("R5 no rst", rreq, 0);
            ticks(l * U - 1); chk("R5 grace irq", irq, 1); chk("R5 grace rst", rreq, 0);
            ticks(1); chk("R5 bite", rreq, 1); chk("R5 irq cleared", irq, 0);
            pulse_len(pl); chk("R9 width dual", pl, RST);
        end
        // R6 dual without interrupt enable
        setup(2, 0, 1);
        ticks(2 * U); chk("R6 rst", rreq, 1); chk("R6 irq", irq, 0);
        pulse_len(pl);

        // R7 kick
        setup(2, 1, 1);
        ticks(2 * U); chk("R7 bark", irq, 1);
        wr_reg(8'h08, 32'h1970); chk("R7 bad kick", irq, 1);
        wr_reg(8'h08, 32'h1971); chk("R7 irq cleared", irq, 0);
        ticks(2 * U - 1); chk("R7 reloaded", irq, 0);
        ticks(1); chk("R7 first stage", irq, 1); chk("R7 no rst", rreq, 0);
        wr_reg(8'h08, 32'h1971);
        ticks(2 * U - 2); wr_reg(8'h08, 32'h1971);
        ticks(2 * U - 1); chk("R7 mid kick", irq, 0);
        ticks(1); chk("R7 mid kick due", irq, 1);

        // R10 stop and restart
        wr_reg(8'h00, mode_w(0, 1, 1)); chk("R10 irq cleared", irq, 0);
        ticks(40); chk("R10 frozen irq", irq, 0); chk("R10 frozen rst", rreq, 0);
        wr_reg(8'h00, mode_w(1, 1, 1));
        ticks(2 * U - 1); chk("R10 reload", irq, 0);
        ticks(1); chk("R10 expire", irq, 1); chk("R10 first stage", rreq, 0);

        // R8 software reset, while disabled
        wr_reg(8'h00, mode_w(0, 0, 0));
        wr_reg(8'h14, 32'h1208); chk("R8 bad code", rreq, 0);
        wr_reg(8'h14, 32'h1209); chk("R8 rst", rreq, 1);
        pulse_len(pl); chk("R9 width swrst", pl, RST);

        // R11 zero length
        setup(0, 0, 0);
        ticks(U - 1); chk("R11 early", rreq, 0);
        ticks(1); chk("R11 due", rreq, 1);
        pulse_len(pl);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule